// File: doc/BRIEF.md
# Serial Link Ready Qualification Monitor

This block sits behind the line-code decoder of a serial link receiver. For each decoded word it gets a strobe and a set of classification bits: a code-field error, three class bits (data, control, idle) and the received flag bit. From these it decides whether the link can be trusted. It raises a ready output only after a run of clean words. It drops ready again on two code-field errors in a row, or, when flag-toggle checking is enabled, when the scrambled flag stops alternating.

Alongside the link verdict it produces per-word indications, registered one cycle after the word. These are an error flag for any word that is not exactly one legal class, a data-available strobe and a control-available strobe. A control word carries meaning only in its low 14 bits. The block also presents the flag bit as a 17th data bit when the flag mode input asks for it. All state moves only on cycles where the word strobe is high. A synchronous active-high reset clears everything.

Top module: `link_ready_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `link_ready`, `word_err`, `data_avail`, `ctrl_avail` and `bit16_out` are 0. The clean-word count, the error history and the previous-flag history are also cleared.
- R2: `link_ready` rises in the cycle after the 64th (QUAL_LEN) consecutive valid word without a code-field error. It stays 0 after the 63rd such word.
- R3: Cycles with `word_vld` low change no qualification state. The clean-word count is neither advanced nor cleared, and `link_ready` holds its value.
- R4: While ready, a single valid word with `code_err` set keeps `link_ready` at 1. A second `code_err` on the very next valid word clears `link_ready` in the cycle after that word.
- R5: Before ready, any valid word with `code_err` set restarts the count, so that 64 further clean words are needed.
- R6: With `toggle_chk` at 1, two consecutive valid words carrying the same `flag_in` value restart qualification. With alternating flags, qualification completes after 64 words.
- R7: With `toggle_chk` at 1, a repeated flag value on consecutive valid words clears `link_ready` in the next cycle. With `toggle_chk` at 0, flag repeats have no effect on `link_ready`.
- R8: `word_err` is 1 in the cycle after a valid word that has `code_err` set, or that does not have exactly one of `is_data`, `is_ctrl` and `is_idle` set.
- R9: In the cycle after a valid error-free word, `data_avail` is 1 only for a data word and `ctrl_avail` is 1 only for a control word. Both are 0 for idle or errored words and after a cycle with `word_vld` low, and they are never 1 together.
- R10: In the cycle after a valid word, `bit16_out` equals `flag_in` when `flag_mode` is 1 and 0 when it is 0. After a cycle with `word_vld` low it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | A decoded word is present this cycle |
| code_err | input | 1 | Code field of the word is in error |
| is_data | input | 1 | Decoder classed the word as data |
| is_ctrl | input | 1 | Decoder classed the word as control |
| is_idle | input | 1 | Decoder classed the word as idle |
| flag_in | input | 1 | Received (descrambled) flag bit |
| flag_mode | input | 1 | Present flag as 17th data bit |
| toggle_chk | input | 1 | Enable flag-toggle checking |
| link_ready | output | 1 | Link qualified |
| word_err | output | 1 | Previous word was invalid |
| data_avail | output | 1 | Previous word was a data word |
| ctrl_avail | output | 1 | Previous word was a control word |
| bit16_out | output | 1 | Gated flag as 17th data bit |

## Verification
A single word can be both the second code error of a pair and a flag repeat, so a drop of ready and a flagged per-word error fall in the same cycle. The bench provokes this by pairing code errors with per-word checks. It also feeds a repeated flag while ready under toggle checking, and judges `word_err` and `link_ready` together in the cycle after. The table walk drives classification vectors through the same path that qualification watches. The directed tests then confirm that these mixed words leave the count in the state the requirements predict.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;

    typedef struct packed {
        logic code_err;
        logic is_data;
        logic is_ctrl;
        logic is_idle;
        logic flag;
    } word_info_t;

    typedef struct packed {
        logic err;
        logic data_av;
        logic ctrl_av;
        logic bit16;
    } word_out_t;

    typedef enum logic [1:0] {
        KIND_BAD  = 2'd0,
        KIND_DATA = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_IDLE = 2'd3
    } word_kind_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_READY = 1'b1
    } link_state_e;

    // Exactly one class bit and a clean code field make a legal word.
    function automatic word_kind_e classify(word_info_t w);
        word_kind_e k;
        k = KIND_BAD;
        if (!w.code_err) begin
            case ({w.is_data, w.is_ctrl, w.is_idle})
                3'b100:  k = KIND_DATA;
                3'b010:  k = KIND_CTRL;
                3'b001:  k = KIND_IDLE;
                default: k = KIND_BAD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/lm_word_classifier.sv
module lm_word_classifier
    import link_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       word_vld,
    input  logic       flag_mode,
    input  word_info_t info,
    output word_out_t  out
);
    word_kind_e kind;
    word_out_t  out_n;

    always_comb begin
        kind  = classify(info);
        out_n = '0;
        if (word_vld) begin
            out_n.err     = (kind == KIND_BAD);
            out_n.data_av = (kind == KIND_DATA);
            out_n.ctrl_av = (kind == KIND_CTRL);
            out_n.bit16   = flag_mode & info.flag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out <= '0;
        else     out <= out_n;
    end

    assert_code_err_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (word_vld && info.code_err) |=> out.err);

    assert_err_blocks_avail_R9: assert property (@(posedge clk) disable iff (rst)
        out.err |-> (!out.data_av && !out.ctrl_av));

    assert_bit16_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !flag_mode |=> !out.bit16);

endmodule

// File: rtl/lm_flag_tracker.sv
module lm_flag_tracker (
    input  logic clk,
    input  logic rst,
    input  logic word_vld,
    input  logic chk_en,
    input  logic flag,
    output logic miss
);
    logic prev_flag;
    logic prev_seen;

    assign miss = word_vld && chk_en && prev_seen && (flag == prev_flag);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_flag <= 1'b0;
            prev_seen <= 1'b0;
        end else if (word_vld) begin
            prev_flag <= flag;
            prev_seen <= 1'b1;
        end
    end

    assert_no_miss_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        !chk_en |-> !miss);

endmodule

// File: rtl/lm_qual_engine.sv
module lm_qual_engine
    import link_mon_pkg::*;
#(
    parameter int QUAL_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic word_vld,
    input  logic code_err,
    input  logic toggle_miss,
    output logic ready
);
    localparam int CNT_W = $clog2(QUAL_LEN + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(QUAL_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_LEN - 1);

    link_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             err_prev, err_prev_n;

    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        err_prev_n = err_prev;
        if (word_vld) begin
            err_prev_n = code_err;
            case (state)
                ST_HUNT: begin
                    if (code_err || toggle_miss) begin
                        cnt_n = '0;
                    end else if (cnt == LAST) begin
                        cnt_n   = FULL;
                        state_n = ST_READY;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_READY: begin
                    if ((code_err && err_prev) || toggle_miss) begin
                        cnt_n   = '0;
                        state_n = ST_HUNT;
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            cnt      <= '0;
            err_prev <= 1'b0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            err_prev <= err_prev_n;
        end
    end

    assign ready = (state == ST_READY);

    assert_rise_needs_full_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (cnt == FULL) && $past(word_vld));

    assert_gap_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !word_vld) |=> ($stable(ready) && $stable(cnt)));

    assert_double_err_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (ready && word_vld && code_err && err_prev) |=> !ready);

    assert_single_err_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (ready && word_vld && code_err && !err_prev && !toggle_miss) |=> ready);

    assert_err_restarts_R5: assert property (@(posedge clk) disable iff (rst)
        (!ready && word_vld && code_err) |=> (cnt == '0) && !ready);

    assert_miss_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (word_vld && toggle_miss) |=> !ready);

endmodule

// File: rtl/link_ready_monitor.sv
module link_ready_monitor
    import link_mon_pkg::*;
#(
    parameter int QUAL_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic word_vld,
    input  logic code_err,
    input  logic is_data,
    input  logic is_ctrl,
    input  logic is_idle,
    input  logic flag_in,
    input  logic flag_mode,
    input  logic toggle_chk,
    output logic link_ready,
    output logic word_err,
    output logic data_avail,
    output logic ctrl_avail,
    output logic bit16_out
);
    word_info_t info;
    word_out_t  wout;
    logic       toggle_miss;

    assign info = '{code_err: code_err, is_data: is_data, is_ctrl: is_ctrl,
                    is_idle: is_idle, flag: flag_in};

    lm_word_classifier u_class (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (word_vld),
        .flag_mode (flag_mode),
        .info      (info),
        .out       (wout)
    );

    lm_flag_tracker u_flag (
        .clk      (clk),
        .rst      (rst),
        .word_vld (word_vld),
        .chk_en   (toggle_chk),
        .flag     (flag_in),
        .miss     (toggle_miss)
    );

    lm_qual_engine #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .word_vld    (word_vld),
        .code_err    (code_err),
        .toggle_miss (toggle_miss),
        .ready       (link_ready)
    );

    assign word_err   = wout.err;
    assign data_avail = wout.data_av;
    assign ctrl_avail = wout.ctrl_av;
    assign bit16_out  = wout.bit16;

    assert_avail_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(data_avail && ctrl_avail));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!link_ready && !word_err && !data_avail && !ctrl_avail && !bit16_out));

endmodule

// File: tb/tb_link_ready_monitor.sv
module tb_link_ready_monitor;
    logic clk = 1'b0;
    logic rst, word_vld, code_err, is_data, is_ctrl, is_idle, flag_in, flag_mode, toggle_chk;
    logic link_ready, word_err, data_avail, ctrl_avail, bit16_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    logic fl     = 1'b0;

    always #5 clk = ~clk;

    link_ready_monitor #(.QUAL_LEN(64)) dut (
        .clk(clk), .rst(rst), .word_vld(word_vld), .code_err(code_err),
        .is_data(is_data), .is_ctrl(is_ctrl), .is_idle(is_idle),
        .flag_in(flag_in), .flag_mode(flag_mode), .toggle_chk(toggle_chk),
        .link_ready(link_ready), .word_err(word_err), .data_avail(data_avail),
        .ctrl_avail(ctrl_avail), .bit16_out(bit16_out)
    );

    // {code_err,data,ctrl,idle,flag,flag_mode, exp err,data,ctrl,bit16}
    localparam logic [9:0] VEC [8] = '{
        10'b010011_0101,
        10'b001010_0010,
        10'b000101_0000,
        10'b110011_1001,
        10'b000000_1000,
        10'b011011_1001,
        10'b010001_0100,
        10'b001011_0011
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic word(input logic ce, input logic d, input logic c, input logic i, input logic f);
        word_vld = 1'b1; code_err = ce; is_data = d; is_ctrl = c; is_idle = i; flag_in = f;
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        word_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clean(input int n, input logic tog);
        for (int k = 0; k < n; k++) begin
            if (tog) fl = ~fl;
            word(1'b0, 1'b1, 1'b0, 1'b0, fl);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; word_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; word_vld = 0; code_err = 0; is_data = 0; is_ctrl = 0; is_idle = 0;
        flag_in = 0; flag_mode = 0; toggle_chk = 0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {link_ready, word_err, data_avail, ctrl_avail}, 4'b0000);
        rst = 1'b0;

        // Classification table walk
        foreach (VEC[k]) begin
            flag_mode = VEC[k][4];
            word(VEC[k][9], VEC[k][8], VEC[k][7], VEC[k][6], VEC[k][5]);
            check($sformatf("R8/R9/R10 vector %0d", k),
                  {word_err, data_avail, ctrl_avail, bit16_out}, VEC[k][3:0]);
        end
        gap(1);
        check("R9/R10 idle cycle clears outputs", {word_err, data_avail, ctrl_avail, bit16_out}, 4'b0000);
        flag_mode = 0;

        // R2 + R3: qualification with a gap in the middle
        do_reset();
        clean(10, 1'b0);
        gap(5);
        check("R3 gap keeps ready low", {3'b0, link_ready}, 4'b0000);
        clean(53, 1'b0);
        check("R2 not ready after 63", {3'b0, link_ready}, 4'b0000);
        clean(1, 1'b0);
        check("R2 ready after 64", {3'b0, link_ready}, 4'b0001);
        gap(7);
        check("R3 gap holds ready", {3'b0, link_ready}, 4'b0001);
        check("R7 repeats ignored with toggle_chk 0", {3'b0, link_ready}, 4'b0001);

        // R4: single error kept, double error drops
        word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 single error keeps ready", {2'b0, word_err, link_ready}, 4'b0011);
        clean(3, 1'b0);
        word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 double error drops ready", {2'b0, word_err, link_ready}, 4'b0010);

        // R5: error during qualification restarts the count
        clean(30, 1'b0);
        word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        clean(63, 1'b0);
        check("R5 restart: not ready after 63", {3'b0, link_ready}, 4'b0000);
        clean(1, 1'b0);
        check("R5 restart: ready after 64", {3'b0, link_ready}, 4'b0001);

        // R6: flag toggle checking during qualification
        toggle_chk = 1'b1;
        do_reset();
        clean(40, 1'b1);
        word(1'b0, 1'b1, 1'b0, 1'b0, fl);
        clean(63, 1'b1);
        check("R6 repeat restarts qualification", {3'b0, link_ready}, 4'b0000);
        clean(1, 1'b1);
        check("R6 toggling qualifies", {3'b0, link_ready}, 4'b0001);

        // R7: repeat while ready drops ready, together with a bad word
        word(1'b0, 1'b0, 1'b0, 1'b0, fl);
        check("R7 repeat drops ready with word_err", {2'b0, word_err, link_ready}, 4'b0010);
        toggle_chk = 1'b0;

        // R1: reset while ready
        clean(64, 1'b0);
        check("R1 ready before reset", {3'b0, link_ready}, 4'b0001);
        rst = 1'b1;
        word(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R1 reset clears ready", {link_ready, word_err, data_avail, ctrl_avail}, 4'b0000);
        rst = 1'b0;
        gap(1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule